// File: doc/BRIEF.md
# IDE Programmed-I/O Access Decoder

This block sits between a host register bus and the task-file ports of a two-channel disk interface. Each host access is compared against five base/size windows (command and control blocks for each channel, plus a bus-master register block). A hit yields a block kind, a channel and a local offset. Task-file accesses are then routed to one of four drives. Bus-master accesses are forwarded to a separate register port. An access that hits no window is flagged.

Each channel keeps a one-bit device select. The bit is captured whenever a byte is written to the drive/head select offset of that channel's command block. The drive number is twice the channel plus that bit. A 32-bit access to the data port is carried out as two 16-bit drive beats, low half first. An I/O-enable input suppresses every side effect. A bus-master-enable input drops writes to the bus-master block. The host issues one access at a time, while `busy` is low, and gets a single-cycle `rsp_valid` pulse back.

Top module: `ide_pio_decode`

## Requirements
- R1: After reset, all five window bases are zero, both device-select bits are zero, and `busy`, `rsp_valid`, `drv_valid` and `bm_valid` are low.
- R2: Windows are checked in this order, and the first hit wins: primary command (size 8), primary control (size 4), secondary command (size 8), secondary control (size 4), bus-master (size 16). `cfg_sel` values 0 to 4 pick the window with the same order.
- R3: In the bus-master window, offsets below 8 go to channel 0 and offsets 8 to 15 go to channel 1. The access appears as one `bm_valid` beat. A read returns `bm_rdata`.
- R4: A base write whose value is zero leaves that window's base unchanged.
- R5: A byte write to command-block offset 6 sets that channel's device bit from data bit 4. The same access is then routed with the new bit. The drive number is 2*channel + device bit.
- R6: With `io_en` low, a hitting access returns zero with no drive beat, no bus-master beat and no device-select update.
- R7: With `bm_en` low, a write to the bus-master window is completed with no `bm_valid` beat. Reads still pass.
- R8: A 32-bit access (`acc_size`=2) to command offset 0 (the data port) gives two drive beats: `drv_hi`=0 with write bits 15:0 first, then `drv_hi`=1 with bits 31:16. Read data is assembled in the same halves.
- R9: A task-file access with an illegal size is rejected with `rsp_err` and no drive beat. The data port takes sizes 1 (16-bit) and 2 (32-bit). All other task-file offsets take size 0 (byte) only.
- R10: An access to a drive whose `drv_present` bit is low returns zero, and a write to it is dropped. Neither gives a drive beat.
- R11: An access that hits no window gives `rsp_err` for one cycle with zero read data.
- R12: `rsp_valid` comes one cycle after acceptance for immediate outcomes, two cycles after for a single beat, and three cycles after for a split access. It is a one-cycle pulse. A byte read returns the low 8 bits of the drive data, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Window base write strobe |
| cfg_sel | input | 3 | Window selected for the base write |
| cfg_base | input | AW | New base value (zero is ignored) |
| io_en | input | 1 | I/O decode enable |
| bm_en | input | 1 | Bus-master write enable |
| acc_valid | input | 1 | Host access request, taken when busy is low |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | AW | Host address |
| acc_size | input | 2 | 0 byte, 1 16-bit, 2 32-bit |
| acc_wdata | input | 32 | Host write data |
| busy | output | 1 | Access in flight or response pending |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion was a miss or an illegal size |
| rsp_rdata | output | 32 | Read data of the completed access |
| drv_present | input | 4 | Drive attached, one bit per drive number |
| drv_valid | output | 1 | Drive beat |
| drv_write | output | 1 | Drive beat is a write |
| drv_idx | output | 2 | Drive number |
| drv_ctrl | output | 1 | 1 = control block, 0 = command block |
| drv_off | output | OW | Offset within the block |
| drv_hi | output | 1 | Beat carries the upper half of a split access |
| drv_wdata | output | 16 | Drive write data |
| drv_rdata | input | 16 | Drive read data, sampled at the end of the beat |
| bm_valid | output | 1 | Bus-master register beat |
| bm_write | output | 1 | Bus-master beat is a write |
| bm_chan | output | 1 | Channel of the bus-master register |
| bm_off | output | OW | Offset within the bus-master window |
| bm_size | output | 2 | Access size of the bus-master beat |
| bm_wdata | output | 32 | Bus-master write data |
| bm_rdata | input | 32 | Bus-master read data, sampled at the end of the beat |

## Verification
Each access is accepted at one edge. Its drive or bus-master beat appears one cycle later, and a split access puts its upper beat in the cycle after that. The response pulse follows the last beat by one cycle, or comes one cycle after acceptance when nothing is forwarded. The bench predicts which of these outcomes applies and samples every output at each falling edge from the first to the last of those cycles. It also checks one more cycle to confirm that the pulse has ended and no further beat occurs.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;
  localparam int NWIN = 5;

  // window index order is also the decode priority
  localparam logic [2:0] W_PCMD  = 3'd0;
  localparam logic [2:0] W_PCTL  = 3'd1;
  localparam logic [2:0] W_SCMD  = 3'd2;
  localparam logic [2:0] W_SCTL  = 3'd3;
  localparam logic [2:0] W_BM    = 3'd4;

  typedef enum logic [1:0] {
    BLK_CMD  = 2'd0,
    BLK_CTL  = 2'd1,
    BLK_BM   = 2'd2,
    BLK_NONE = 2'd3
  } blk_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } asz_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2
  } st_e;
endpackage

// File: rtl/ide_win_match.sv
module ide_win_match #(
  parameter int AW   = 16,
  parameter int OW   = 5,
  parameter int SIZE = 8
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [OW-1:0] off
);
  logic [AW:0] limit;

  assign limit = {1'b0, base} + (AW+1)'(SIZE);
  assign hit   = (addr >= base) && ({1'b0, addr} < limit);
  assign off   = OW'(addr - base);
endmodule

// File: rtl/ide_win_prio.sv
module ide_win_prio
  import ide_dec_pkg::*;
#(
  parameter int OW       = 5,
  parameter int BM_SPLIT = 8
) (
  input  logic [NWIN-1:0]         hit,
  input  logic [NWIN-1:0][OW-1:0] offs,
  output logic                    any_hit,
  output blk_e                    blk,
  output logic                    chan,
  output logic [OW-1:0]           off
);
  logic [2:0] sel;

  always_comb begin
    sel = W_BM;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (hit[i]) sel = 3'(i);
    end
  end

  always_comb begin
    any_hit = |hit;
    off     = offs[sel];
    chan    = 1'b0;
    blk     = BLK_NONE;
    if (any_hit) begin
      unique case (sel)
        W_PCMD:  blk = BLK_CMD;
        W_PCTL:  blk = BLK_CTL;
        W_SCMD:  begin blk = BLK_CMD; chan = 1'b1; end
        W_SCTL:  begin blk = BLK_CTL; chan = 1'b1; end
        default: begin blk = BLK_BM;  chan = (off >= OW'(BM_SPLIT)); end
      endcase
    end
  end
endmodule

// File: rtl/ide_pio_decode.sv
module ide_pio_decode
  import ide_dec_pkg::*;
#(
  parameter int AW       = 16,
  parameter int OW       = 5,
  parameter int CMD_SZ   = 8,
  parameter int CTL_SZ   = 4,
  parameter int BM_SZ    = 16,
  parameter int BM_SPLIT = 8,
  parameter int DATA_OFF = 0,
  parameter int SEL_OFF  = 6,
  parameter int DEV_BIT  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_base,
  input  logic          io_en,
  input  logic          bm_en,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [AW-1:0] acc_addr,
  input  logic [1:0]    acc_size,
  input  logic [31:0]   acc_wdata,
  output logic          busy,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [31:0]   rsp_rdata,
  input  logic [3:0]    drv_present,
  output logic          drv_valid,
  output logic          drv_write,
  output logic [1:0]    drv_idx,
  output logic          drv_ctrl,
  output logic [OW-1:0] drv_off,
  output logic          drv_hi,
  output logic [15:0]   drv_wdata,
  input  logic [15:0]   drv_rdata,
  output logic          bm_valid,
  output logic          bm_write,
  output logic          bm_chan,
  output logic [OW-1:0] bm_off,
  output logic [1:0]    bm_size,
  output logic [31:0]   bm_wdata,
  input  logic [31:0]   bm_rdata
);
  function automatic int win_sz(input int i);
    case (i)
      0, 2:    return CMD_SZ;
      1, 3:    return CTL_SZ;
      default: return BM_SZ;
    endcase
  endfunction

  logic [AW-1:0]          base_q [NWIN];
  logic [1:0]             dev_q;
  logic [NWIN-1:0]        w_hit;
  logic [NWIN-1:0][OW-1:0] w_off;
  logic                   any_hit;
  blk_e                   blk;
  logic                   chan;
  logic [OW-1:0]          off;
  st_e                    state;
  logic                   two_beat, byte_acc;
  logic [15:0]            wdata_hi;

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    ide_win_match #(.AW(AW), .OW(OW), .SIZE(win_sz(g))) u_match (
      .base (base_q[g]),
      .addr (acc_addr),
      .hit  (w_hit[g]),
      .off  (w_off[g])
    );
  end

  ide_win_prio #(.OW(OW), .BM_SPLIT(BM_SPLIT)) u_prio (
    .hit     (w_hit),
    .offs    (w_off),
    .any_hit (any_hit),
    .blk     (blk),
    .chan    (chan),
    .off     (off)
  );

  asz_e asz;
  logic accept, is_data, size_ok, sel_hit, dev_n;
  logic [1:0] idx_n;

  assign asz     = asz_e'(acc_size);
  assign busy    = (state != ST_IDLE) | rsp_valid;
  assign accept  = acc_valid & ~busy;
  assign is_data = (blk == BLK_CMD) && (off == OW'(DATA_OFF));
  assign size_ok = is_data ? (asz == SZ_HALF || asz == SZ_WORD) : (asz == SZ_BYTE);
  assign sel_hit = acc_write && (blk == BLK_CMD) && (off == OW'(SEL_OFF)) && (asz == SZ_BYTE);
  assign dev_n   = sel_hit ? acc_wdata[DEV_BIT] : dev_q[chan];
  assign idx_n   = {chan, dev_n};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NWIN; i++) base_q[i] <= '0;
      dev_q     <= '0;
      state     <= ST_IDLE;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
      drv_valid <= 1'b0;
      drv_write <= 1'b0;
      drv_idx   <= '0;
      drv_ctrl  <= 1'b0;
      drv_off   <= '0;
      drv_hi    <= 1'b0;
      drv_wdata <= '0;
      bm_valid  <= 1'b0;
      bm_write  <= 1'b0;
      bm_chan   <= 1'b0;
      bm_off    <= '0;
      bm_size   <= '0;
      bm_wdata  <= '0;
      two_beat  <= 1'b0;
      byte_acc  <= 1'b0;
      wdata_hi  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      if (cfg_we && cfg_base != '0 && int'(cfg_sel) < NWIN)
        base_q[cfg_sel] <= cfg_base;

      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            rsp_rdata <= '0;
            if (!any_hit) begin
              rsp_valid <= 1'b1;
              rsp_err   <= 1'b1;
            end else if (!io_en) begin
              rsp_valid <= 1'b1;
            end else if (blk == BLK_BM) begin
              if (acc_write && !bm_en) begin
                rsp_valid <= 1'b1;
              end else begin
                bm_valid <= 1'b1;
                bm_write <= acc_write;
                bm_chan  <= chan;
                bm_off   <= off;
                bm_size  <= acc_size;
                bm_wdata <= acc_wdata;
                state    <= ST_LO;
              end
            end else if (!size_ok) begin
              rsp_valid <= 1'b1;
              rsp_err   <= 1'b1;
            end else begin
              if (sel_hit) dev_q[chan] <= acc_wdata[DEV_BIT];
              if (!drv_present[idx_n]) begin
                rsp_valid <= 1'b1;
              end else begin
                drv_valid <= 1'b1;
                drv_write <= acc_write;
                drv_idx   <= idx_n;
                drv_ctrl  <= (blk == BLK_CTL);
                drv_off   <= off;
                drv_hi    <= 1'b0;
                drv_wdata <= acc_wdata[15:0];
                wdata_hi  <= acc_wdata[31:16];
                two_beat  <= is_data && (asz == SZ_WORD);
                byte_acc  <= (asz == SZ_BYTE);
                state     <= ST_LO;
              end
            end
          end
        end
        ST_LO: begin
          if (bm_valid) begin
            bm_valid  <= 1'b0;
            rsp_valid <= 1'b1;
            if (!bm_write) rsp_rdata <= bm_rdata;
            state     <= ST_IDLE;
          end else begin
            if (!drv_write)
              rsp_rdata[15:0] <= byte_acc ? {8'h00, drv_rdata[7:0]} : drv_rdata;
            if (two_beat) begin
              drv_hi    <= 1'b1;
              drv_wdata <= wdata_hi;
              state     <= ST_HI;
            end else begin
              drv_valid <= 1'b0;
              rsp_valid <= 1'b1;
              state     <= ST_IDLE;
            end
          end
        end
        default: begin
          if (!drv_write) rsp_rdata[31:16] <= drv_rdata;
          drv_valid <= 1'b0;
          drv_hi    <= 1'b0;
          rsp_valid <= 1'b1;
          state     <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/ide_pio_decode_chk.sv
module ide_pio_decode_chk (
  input logic        clk,
  input logic        rst,
  input logic        io_en,
  input logic        bm_en,
  input logic        acc_valid,
  input logic        busy,
  input logic        rsp_valid,
  input logic        rsp_err,
  input logic [31:0] rsp_rdata,
  input logic        drv_valid,
  input logic        drv_hi,
  input logic [1:0]  drv_idx,
  input logic [3:0]  drv_present,
  input logic        bm_valid,
  input logic        bm_write
);
  a_r12_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  a_r8_low_first: assert property (@(posedge clk) disable iff (rst)
    (drv_valid && drv_hi) |-> $past(drv_valid && !drv_hi));

  a_r6_io_off_quiet: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !busy && !io_en) |=> (!drv_valid && !bm_valid));

  a_r11_err_zero: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> (rsp_rdata == 32'd0));

  a_r7_bm_write_gate: assert property (@(posedge clk) disable iff (rst)
    (bm_valid && bm_write) |-> $past(bm_en));

  a_r10_present_only: assert property (@(posedge clk) disable iff (rst)
    (drv_valid && !drv_hi) |-> $past(drv_present[drv_idx]));

  a_r12_beats_busy: assert property (@(posedge clk) disable iff (rst)
    (drv_valid || bm_valid) |-> busy);
endmodule

bind ide_pio_decode ide_pio_decode_chk u_chk (.*);

// File: tb/ide_pio_decode_bench.sv
module ide_pio_decode_bench;
  localparam int AW = 16;
  localparam int OW = 5;

  logic          clk = 1'b0;
  logic          rst;
  logic          cfg_we;
  logic [2:0]    cfg_sel;
  logic [AW-1:0] cfg_base;
  logic          io_en, bm_en;
  logic          acc_valid, acc_write;
  logic [AW-1:0] acc_addr;
  logic [1:0]    acc_size;
  logic [31:0]   acc_wdata;
  logic          busy, rsp_valid, rsp_err;
  logic [31:0]   rsp_rdata;
  logic [3:0]    drv_present;
  logic          drv_valid, drv_write, drv_ctrl, drv_hi;
  logic [1:0]    drv_idx;
  logic [OW-1:0] drv_off;
  logic [15:0]   drv_wdata, drv_rdata;
  logic          bm_valid, bm_write, bm_chan;
  logic [OW-1:0] bm_off, bm_off_m;
  logic [1:0]    bm_size;
  logic [31:0]   bm_wdata, bm_rdata;

  always #2 clk = ~clk;

  // drive and bus-master models answer from the beat fields
  assign drv_rdata = {4'hC, drv_hi, drv_idx, drv_off, 4'h5};
  assign bm_off_m  = bm_off;
  assign bm_rdata  = {8'hB0, 7'd0, bm_chan, 11'd0, bm_off_m};

  ide_pio_decode u_ide_pio_decode (.*);

  int checks = 0, failures = 0;
  bit done = 1'b0;
  int m_base [5];
  bit m_dev [2];
  int m_size [5] = '{8, 4, 8, 4, 16};

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cfg(input int sel, input int b);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_base = AW'(b);
    @(negedge clk);
    cfg_we = 1'b0;
    if (b != 0) m_base[sel] = b;
  endtask

  // kinds: 0 immediate, 1 bus-master beat, 2 one drive beat, 3 two drive beats
  task automatic acc(input bit w, input int addr, input int sz,
                     input logic [31:0] wd, input string req);
    int win = -1, off = 0, ch = 0, kind = 0, idx = 0;
    bit err = 1'b0, dat;
    logic [31:0] exp_rd = 0;
    logic [15:0] lo, hi;
    for (int i = 0; i < 5; i++)
      if (win < 0 && addr >= m_base[i] && addr < m_base[i] + m_size[i]) begin
        win = i; off = addr - m_base[i];
      end
    if (win < 0) err = 1'b1;
    else if (io_en) begin
      if (win == 4) begin
        ch = (off >= 8) ? 1 : 0;
        if (!(w && !bm_en)) begin
          kind = 1;
          if (!w) exp_rd = {8'hB0, 7'd0, ch[0], 11'd0, 5'(off)};
        end
      end else begin
        ch  = win / 2;
        dat = (win % 2 == 0) && off == 0;
        if (dat ? !(sz == 1 || sz == 2) : sz != 0) err = 1'b1;
        else begin
          if (w && win % 2 == 0 && off == 6 && sz == 0) m_dev[ch] = wd[4];
          idx = 2 * ch + int'(m_dev[ch]);
          if (drv_present[idx]) begin
            kind = (dat && sz == 2) ? 3 : 2;
            lo = {4'hC, 1'b0, 2'(idx), 5'(off), 4'h5};
            hi = {4'hC, 1'b1, 2'(idx), 5'(off), 4'h5};
            if (!w) exp_rd = (kind == 3) ? {hi, lo} : (sz == 0) ? {24'd0, lo[7:0]} : {16'd0, lo};
          end
        end
      end
    end
    @(negedge clk);
    while (busy) @(negedge clk);
    acc_valid = 1'b1; acc_write = w; acc_addr = AW'(addr);
    acc_size = 2'(sz); acc_wdata = wd;
    @(negedge clk);
    acc_valid = 1'b0;
    if (kind == 1) begin
      chk(bm_valid && !drv_valid && !rsp_valid, req, "bm beat", {29'd0, bm_valid, drv_valid, rsp_valid}, 32'h4);
      chk(bm_chan == ch[0] && bm_off == 5'(off) && bm_write == w, req, "bm fields",
          {26'd0, bm_chan, bm_off}, {26'd0, ch[0], 5'(off)});
      @(negedge clk);
    end else if (kind >= 2) begin
      chk(drv_valid && !drv_hi && !rsp_valid && !bm_valid, req, "drive beat lo",
          {29'd0, drv_valid, drv_hi, rsp_valid}, 32'h4);
      chk(drv_idx == 2'(idx) && drv_off == 5'(off) && drv_write == w && drv_ctrl == (win % 2 == 1),
          req, "drive fields", {25'd0, drv_ctrl, drv_idx, drv_off}, {25'd0, win % 2 == 1, 2'(idx), 5'(off)});
      if (w) chk(drv_wdata == wd[15:0], req, "wdata lo", {16'd0, drv_wdata}, {16'd0, wd[15:0]});
      @(negedge clk);
      if (kind == 3) begin
        chk(drv_valid && drv_hi && !rsp_valid, req, "drive beat hi",
            {29'd0, drv_valid, drv_hi, rsp_valid}, 32'h6);
        if (w) chk(drv_wdata == wd[31:16], req, "wdata hi", {16'd0, drv_wdata}, {16'd0, wd[31:16]});
        @(negedge clk);
      end
    end
    chk(rsp_valid && rsp_err == err && !drv_valid && !bm_valid, req, "response",
        {28'd0, rsp_valid, rsp_err, drv_valid, bm_valid}, {28'd0, 1'b1, err, 2'b00});
    chk(rsp_rdata == exp_rd, req, "read data", rsp_rdata, exp_rd);
    @(negedge clk);
    chk(!rsp_valid && !drv_valid && !bm_valid, req, "idle after",
        {29'd0, rsp_valid, drv_valid, bm_valid}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_sel = '0; cfg_base = '0;
    io_en = 1'b1; bm_en = 1'b1; acc_valid = 1'b0; acc_write = 1'b0;
    acc_addr = '0; acc_size = '0; acc_wdata = '0; drv_present = 4'b1011;
    for (int i = 0; i < 5; i++) m_base[i] = 0;
    m_dev[0] = 1'b0; m_dev[1] = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle outputs, zero bases (address 2 lands in primary command)
    chk(!busy && !rsp_valid && !drv_valid && !bm_valid, "R1", "reset outputs",
        {28'd0, busy, rsp_valid, drv_valid, bm_valid}, 32'h0);
    acc(1'b0, 2, 0, 0, "R1");
    // R2: overlap bus-master onto primary command, command wins
    cfg(0, 'h100); cfg(1, 'h10C); cfg(2, 'h180); cfg(3, 'h18C); cfg(4, 'h104);
    acc(1'b0, 'h105, 0, 0, "R2");
    acc(1'b0, 'h10D, 0, 0, "R2");
    cfg(4, 'h200);
    // R4: zero base write ignored
    cfg(2, 0);
    acc(1'b0, 'h181, 0, 0, "R4");
    // R5: device select on each channel
    acc(1'b1, 'h106, 0, 32'h10, "R5");
    acc(1'b0, 'h102, 0, 0, "R5");
    acc(1'b1, 'h186, 0, 32'h10, "R5");
    acc(1'b0, 'h18E, 0, 0, "R5");
    // R10: drive 2 absent
    acc(1'b1, 'h186, 0, 32'h00, "R10");
    acc(1'b0, 'h183, 0, 0, "R10");
    acc(1'b1, 'h180, 1, 32'h1234, "R10");
    // R8: split data port on drive 1, R12 half read
    acc(1'b0, 'h100, 2, 0, "R8");
    acc(1'b1, 'h100, 2, 32'hAAAA5555, "R8");
    acc(1'b0, 'h100, 1, 0, "R12");
    // R9: illegal sizes
    acc(1'b0, 'h100, 0, 0, "R9");
    acc(1'b1, 'h102, 1, 32'hFFFF, "R9");
    acc(1'b0, 'h101, 2, 0, "R9");
    // R3: bus-master channel split
    acc(1'b0, 'h203, 2, 0, "R3");
    acc(1'b0, 'h20A, 0, 0, "R3");
    acc(1'b1, 'h20F, 0, 32'h5A, "R3");
    // R7: bus-master writes gated
    bm_en = 1'b0;
    acc(1'b1, 'h208, 0, 32'h01, "R7");
    acc(1'b0, 'h208, 0, 0, "R7");
    bm_en = 1'b1;
    // R6: io disabled, select write must not stick
    io_en = 1'b0;
    acc(1'b1, 'h106, 0, 32'h00, "R6");
    acc(1'b0, 'h102, 0, 0, "R6");
    io_en = 1'b1;
    acc(1'b0, 'h102, 0, 0, "R6");
    // R11: miss
    acc(1'b0, 'h300, 0, 0, "R11");
    acc(1'b1, 'h0FF, 0, 32'h1, "R11");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule